// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

On a cache miss this block fetches one 32-byte line from a slower second-level memory that has a 64-bit read port. The line arrives as four 64-bit beats. The fetch starts with the beat that holds the requested address and then continues around the line in wrap-around order. As each beat returns, it goes to the core on a forwarding port and, in the same cycle, to the cache data array on a line-write port. The core can therefore resume on the critical word while the rest of the line is still being filled. When every beat has been written, the block raises a one-cycle line-valid pulse.

For an access marked non-cacheable, the block reads only the addressed beat and forwards it. It writes nothing into the cache and does not raise line-valid. Tag lookup, replacement and write-back belong to other logic. The caller decides whether a sequential access has crossed into a new 32-byte line and therefore needs a fill.

The memory port has a fixed latency of `MEM_LAT` cycles. The data for a read that is sampled at clock edge n is present on `mem_rd_data` in the cycle that follows edge n+MEM_LAT-1. With the default of 7, the first beat reaches the core 7 cycles after the request is accepted.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_en`, `fwd_valid`, `lw_en` and `line_valid` are 0.
- R2: A cacheable request is accepted at the edge where `req_valid` and `req_ready` are both high. The block then asserts `mem_rd_en` for exactly four consecutive cycles, starting in the cycle after acceptance. Every read address has the request's line bits (address bits 31:5), a beat index in bits 4:3, and zeros in bits 2:0.
- R3: The first beat read and the first beat forwarded are beat index `req_addr[4:3]`. `fwd_crit` is 1 on that beat only.
- R4: After the critical beat k, the block reads and forwards beats (k+1) mod 4, (k+2) mod 4 and (k+3) mod 4, in that order.
- R5: The first beat is forwarded in the cycle after the 7th edge following acceptance, and the other beats follow on consecutive cycles. Each forwarded beat carries the memory data for its address. In the same cycle, `lw_en` writes that data with the same beat index and the line base address (bits 4:0 zero).
- R6: `line_valid` is a one-cycle pulse, carrying the line base address, in the cycle after the fourth beat is written. `req_ready` returns to 1 in that same cycle.
- R7: A non-cacheable request issues one read, of the addressed beat. That beat is forwarded 7 cycles after acceptance with `fwd_crit`=1. `lw_en` and `line_valid` stay 0, and `req_ready` returns in the following cycle.
- R8: `req_ready` stays 0 from acceptance until the operation completes. A `req_valid` that arrives during that time starts no reads and changes no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Requested byte address |
| req_cacheable | input | 1 | 1 = fill a line, 0 = single-beat fetch |
| req_ready | output | 1 | Engine idle, request can be taken |
| mem_rd_en | output | 1 | Read strobe to second-level memory |
| mem_rd_addr | output | ADDR_W | Beat-aligned read address |
| mem_rd_data | input | DATA_W | Read data, valid MEM_LAT cycles after the read |
| lw_en | output | 1 | Write one beat into the line |
| lw_line_addr | output | ADDR_W | Line base address for the write |
| lw_beat | output | $clog2(BEATS) | Beat index within the line |
| lw_data | output | DATA_W | Beat data to write |
| fwd_valid | output | 1 | Beat forwarded to the core |
| fwd_beat | output | $clog2(BEATS) | Index of the forwarded beat |
| fwd_crit | output | 1 | Forwarded beat holds the requested word |
| fwd_data | output | DATA_W | Forwarded beat data |
| line_valid | output | 1 | Whole line written (pulse) |
| line_addr | output | ADDR_W | Base address of the completed line |

## Verification
The bench targets each of the four critical-beat positions, and in particular beat 3, where the order must wrap straight back to beat 0. A design that mishandles the wrap would read the wrong address or report a non-incrementing beat index. Uncached requests check that no line write or line-valid pulse appears and that the engine frees up after one beat instead of four. Requests held on `req_valid` throughout a fill check that a busy engine neither restarts nor picks up the new address. Cycle-exact sampling of the first data cycle and of the line-valid pulse catches a latency that is off by one.

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int BEATS   = 4,
  parameter int MEM_LAT = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_cacheable,
  output logic                       req_ready,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic [DATA_W-1:0]          mem_rd_data,
  output logic                       lw_en,
  output logic [ADDR_W-1:0]          lw_line_addr,
  output logic [$clog2(BEATS)-1:0]   lw_beat,
  output logic [DATA_W-1:0]          lw_data,
  output logic                       fwd_valid,
  output logic [$clog2(BEATS)-1:0]   fwd_beat,
  output logic                       fwd_crit,
  output logic [DATA_W-1:0]          fwd_data,
  output logic                       line_valid,
  output logic [ADDR_W-1:0]          line_addr
);
  localparam int IDX_W    = $clog2(BEATS);
  localparam int OFF_W    = $clog2(DATA_W / 8);
  localparam int LINE_LSB = IDX_W + OFF_W;
  localparam int CNT_W    = $clog2(MEM_LAT + BEATS + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(MEM_LAT);

  logic                       busy, cached_q, lv_q;
  logic [IDX_W-1:0]           crit_q;
  logic [ADDR_W-LINE_LSB-1:0] line_q;
  logic [CNT_W-1:0]           cnt, nb;
  logic                       accept, issue, ret, last;
  logic [IDX_W-1:0]           issue_k, ret_k;
  logic                       unused_lo;

  assign unused_lo = &req_addr[OFF_W-1:0];
  assign nb        = cached_q ? CNT_W'(BEATS) : CNT_W'(1);
  assign accept    = req_valid && !busy;
  assign issue     = busy && (cnt < nb);
  assign ret       = busy && (cnt >= LAT_C) && (cnt < LAT_C + nb);
  assign last      = busy && (cnt == LAT_C + nb - CNT_W'(1));
  assign issue_k   = crit_q + cnt[IDX_W-1:0];
  assign ret_k     = crit_q + IDX_W'(cnt - LAT_C);

  assign req_ready    = !busy;
  assign mem_rd_en    = issue;
  assign mem_rd_addr  = {line_q, issue_k, {OFF_W{1'b0}}};
  assign fwd_valid    = ret;
  assign fwd_beat     = ret_k;
  assign fwd_crit     = ret && (ret_k == crit_q);
  assign fwd_data     = mem_rd_data;
  assign lw_en        = ret && cached_q;
  assign lw_line_addr = {line_q, {LINE_LSB{1'b0}}};
  assign lw_beat      = ret_k;
  assign lw_data      = mem_rd_data;
  assign line_valid   = lv_q;
  assign line_addr    = {line_q, {LINE_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cached_q <= 1'b0;
      lv_q     <= 1'b0;
      crit_q   <= '0;
      line_q   <= '0;
      cnt      <= '0;
    end else begin
      lv_q <= last && cached_q;
      if (accept) begin
        busy     <= 1'b1;
        cached_q <= req_cacheable;
        crit_q   <= req_addr[LINE_LSB-1:OFF_W];
        line_q   <= req_addr[ADDR_W-1:LINE_LSB];
        cnt      <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_FIRST_IS_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !$past(fwd_valid) |-> fwd_crit); // R3
  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && $past(fwd_valid) |-> fwd_beat == IDX_W'($past(fwd_beat) + 1'b1)); // R4
  AST_LV_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> $past(lw_en) && !lw_en); // R6
  AST_NC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !cached_q |-> !lw_en && !line_valid); // R7
  AST_BUSY_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid || mem_rd_en) |-> !req_ready); // R8
  AST_READ_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr[ADDR_W-1:LINE_LSB] == $past(mem_rd_addr[ADDR_W-1:LINE_LSB])); // R2
endmodule

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 64, NB = 4, LAT = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_cacheable = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, mem_rd_en, lw_en, fwd_valid, fwd_crit, line_valid;
  logic [AW-1:0] mem_rd_addr, lw_line_addr, line_addr;
  logic [DW-1:0] mem_rd_data, lw_data, fwd_data;
  logic [1:0] lw_beat, fwd_beat;
  logic [AW-1:0] pipe_a [LAT];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwf_line_fill #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB), .MEM_LAT(LAT)) dut (
    .clk, .rst_n, .req_valid, .req_addr, .req_cacheable, .req_ready,
    .mem_rd_en, .mem_rd_addr, .mem_rd_data, .lw_en, .lw_line_addr, .lw_beat,
    .lw_data, .fwd_valid, .fwd_beat, .fwd_crit, .fwd_data, .line_valid, .line_addr);

  function automatic logic [DW-1:0] memf(logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0F0F, ~a};
  endfunction

  always @(posedge clk) begin
    pipe_a[0] <= mem_rd_addr;
    for (int i = 1; i < LAT; i++) pipe_a[i] <= pipe_a[i-1];
  end
  assign mem_rd_data = memf(pipe_a[LAT-1]);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [AW-1:0] a, logic c, logic hold);
    logic [AW-1:0] base;
    logic [1:0] k;
    int n;
    base = {a[AW-1:5], 5'd0};
    k = a[4:3];
    n = c ? NB : 1;
    req_valid = 1; req_addr = a; req_cacheable = c;
    @(posedge clk);
    #1;
    if (hold) begin
      req_addr = a ^ 32'hFFFF_FFE0; req_cacheable = ~c;
    end else req_valid = 0;
    for (int j = 0; j <= LAT + n; j++) begin
      logic [1:0] ib, rb;
      ib = k + 2'(j);
      rb = k + 2'(j - LAT);
      @(negedge clk);
      chk(c ? "R2 rd_en" : "R7 rd_en", DW'(mem_rd_en), DW'(j < n));
      if (j < n) chk("R3 R4 rd_addr", DW'(mem_rd_addr), DW'({base[AW-1:5], ib, 3'd0}));
      chk("R5 fwd_valid", DW'(fwd_valid), DW'(j >= LAT && j < LAT + n));
      if (j >= LAT && j < LAT + n) begin
        chk("R4 fwd_beat", DW'(fwd_beat), DW'(rb));
        chk("R3 fwd_crit", DW'(fwd_crit), DW'(j == LAT));
        chk("R5 fwd_data", fwd_data, memf({base[AW-1:5], rb, 3'd0}));
        chk(c ? "R5 lw_en" : "R7 lw_en", DW'(lw_en), DW'(c));
        if (c) begin
          chk("R5 lw_beat", DW'(lw_beat), DW'(rb));
          chk("R5 lw_data", lw_data, memf({base[AW-1:5], rb, 3'd0}));
          chk("R5 lw_line_addr", DW'(lw_line_addr), DW'(base));
        end
      end else chk("R7 lw idle", DW'(lw_en), 0);
      chk(c ? "R6 line_valid" : "R7 line_valid", DW'(line_valid), DW'(c && j == LAT + n));
      if (c && j == LAT + n) chk("R6 line_addr", DW'(line_addr), DW'(base));
      chk("R8 req_ready", DW'(req_ready), DW'(j >= LAT + n));
    end
    req_valid = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", DW'(req_ready), 1);
    chk("R1 idle", DW'({mem_rd_en, fwd_valid, lw_en, line_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) run(32'h1000_0040 | 32'(k << 3) | 32'h5, 1, 0);
    run(32'h2000_0018, 1, 1);
    run(32'h3000_0008, 0, 0);
    run(32'h3000_001C, 0, 1);
    for (int i = 0; i < 40; i++) run($urandom, 1'($urandom), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule